// File: doc/BRIEF.md
# Three-Phase Bridge Fault Supervisor

This block sits between the control logic of a six-output three-phase gate driver and its output stages and decides, on every clock, whether the outputs may be active. It receives already digitized condition flags: an over-current trip, a logic-supply undervoltage, one high-side supply undervoltage per phase, and an enable. From them it drives a global kill that turns all six gate outputs off, a per-phase inhibit that turns off only one high-side output, and an active-low fault flag for the system.

An over-current trip must stay high for a programmed blanking window before it counts, which rejects short glitches. A qualified trip sets a latch in which setting wins over clearing. Once the trip input has been low for a programmed number of cycles, the latch clears itself. Every return of the raw trip input restarts that count. Logic-supply undervoltage kills the outputs and reports a fault, but nothing about it is stored. The enable input and the high-side undervoltage flags only gate outputs and never touch the fault flag. Both delays are parameters in clock cycles. The defaults assume a 200 MHz clock: a 30-cycle blanking window (150 ns) and a 330,000-cycle clear delay (1.65 ms).

Top module: `drv_fault_supervisor`

## Requirements
- R1: A trip qualified at a clock edge sets `kill_o` to 1 from that edge onward, turning all six gate outputs off together.
- R2: `fault_n_o` is 0 exactly while the over-current latch is set or `vcc_uv_i` was 1 at the last edge. Otherwise it is 1.
- R3: While the latch is set, a trip input that stays high keeps the fault and kill asserted however long it lasts. A set request always beats the clear timer.
- R4: After the trip input falls, `fault_n_o` stays 0 for CLR_CYC-1 edges and returns to 1 (and `kill_o` to 0, other causes absent) at the CLR_CYC-th consecutive edge with the trip low.
- R5: `vcc_uv_i` = 1 sets `kill_o` = 1 and `fault_n_o` = 0 at the next edge. Both release at the first edge after it returns to 0, with no stored state.
- R6: `hs_uv_i[p]` = 1 sets only `hs_inhibit_o[p]` at the next edge. Other phases, `kill_o` and `fault_n_o` are unaffected.
- R7: `enable_i` = 0 sets `kill_o` = 1 at the next edge without changing `fault_n_o`. Kill releases at the first edge after enable returns to 1.
- R8: A trip input sampled high on fewer than BLANK_CYC consecutive edges has no effect. It qualifies on the BLANK_CYC-th consecutive high edge.
- R9: While reset is asserted, `kill_o` = 1, all `hs_inhibit_o` bits = 1 and `fault_n_o` = 1.
- R10: Any edge at which the raw trip input is high, qualified or not, restarts the clear count, so a full CLR_CYC low edges are needed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Digitized over-current trip flag, active high |
| vcc_uv_i | input | 1 | Logic-supply undervoltage flag, active high |
| hs_uv_i | input | NUM_PH | Per-phase high-side supply undervoltage flags |
| enable_i | input | 1 | Output enable, active high |
| kill_o | output | 1 | Forces all six gate outputs off |
| hs_inhibit_o | output | NUM_PH | Forces one phase's high-side output off |
| fault_n_o | output | 1 | Fault flag, active low |

## Verification
Every output is a single register fed from the inputs, so enable, logic-supply undervoltage and high-side undervoltage show up at the first edge after they change. A trip shows up at the BLANK_CYC-th consecutive high edge, and the release comes at the CLR_CYC-th consecutive low edge. The bench changes inputs and samples outputs one nanosecond after a rising edge. It counts edges with a step task, so each check is taken at the exact edge count where an output changes and again one edge before it. The glitch test holds the trip for BLANK_CYC-1 edges, and the restart test inserts a single-edge trip partway through a clear count.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;

  // Counter width able to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  typedef struct packed {
    logic kill;
    logic fault_n;
  } sup_out_t;

endpackage

// File: rtl/trip_blanker.sv
module trip_blanker #(
  parameter int BLANK_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  output logic qual_o
);
  import drv_sup_pkg::*;

  localparam int BW = cnt_width(BLANK_CYC);
  localparam logic [BW-1:0] RUN_LIM = BW'(BLANK_CYC - 1);

  logic [BW-1:0] run_q, run_d;

  // Count consecutive high samples, saturating at the limit
  always_comb begin
    run_d = '0;
    if (trip_i) begin
      run_d = (run_q == RUN_LIM) ? run_q : run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign qual_o = trip_i && (run_q == RUN_LIM);

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_LIM); // R8

  generate
    if (BLANK_CYC > 1) begin : g_blank_chk
      AST_QUAL_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> $past(trip_i)); // R8
    end
  endgenerate

endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch #(
  parameter int CLR_CYC = 330000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_raw_i,
  input  logic trip_qual_i,
  output logic oc_next_o,
  output logic oc_q_o
);
  import drv_sup_pkg::*;

  localparam int CW = cnt_width(CLR_CYC);
  localparam logic [CW-1:0] CLR_LIM = CW'(CLR_CYC - 1);

  logic [CW-1:0] clr_q, clr_d;
  logic          oc_q;
  logic          clr_done;

  assign clr_done = oc_q && !trip_raw_i && (clr_q == CLR_LIM);

  always_comb begin
    clr_d = clr_q;
    if (trip_raw_i || !oc_q || clr_done) clr_d = '0;
    else                                 clr_d = clr_q + 1'b1;
  end

  // Set dominates: a qualified trip overrides a finishing clear count
  assign oc_next_o = trip_qual_i || (oc_q && !clr_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q  <= 1'b0;
      clr_q <= '0;
    end else begin
      oc_q  <= oc_next_o;
      clr_q <= clr_d;
    end
  end

  assign oc_q_o = oc_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    trip_qual_i |=> oc_q); // R3
  AST_CLR_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q <= CLR_LIM); // R4
  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    trip_raw_i |=> (clr_q == '0)); // R10
  AST_FALL_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_q) |-> ($past(clr_q) == CLR_LIM && !$past(trip_raw_i))); // R4

endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor #(
  parameter int NUM_PH    = 3,
  parameter int BLANK_CYC = 30,
  parameter int CLR_CYC   = 330000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trip_i,
  input  logic              vcc_uv_i,
  input  logic [NUM_PH-1:0] hs_uv_i,
  input  logic              enable_i,
  output logic              kill_o,
  output logic [NUM_PH-1:0] hs_inhibit_o,
  output logic              fault_n_o
);
  import drv_sup_pkg::*;

  logic     trip_qual;
  logic     oc_next, oc_q;
  sup_out_t out_d, out_q;
  logic [NUM_PH-1:0] inh_d, inh_q;

  trip_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk    (clk),
    .rst_n  (rst_n),
    .trip_i (trip_i),
    .qual_o (trip_qual)
  );

  oc_fault_latch #(.CLR_CYC(CLR_CYC)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip_raw_i  (trip_i),
    .trip_qual_i (trip_qual),
    .oc_next_o   (oc_next),
    .oc_q_o      (oc_q)
  );

  always_comb begin
    out_d.kill    = oc_next || vcc_uv_i || !enable_i;
    out_d.fault_n = !(oc_next || vcc_uv_i);
  end

  generate
    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
      always_comb inh_d[p] = hs_uv_i[p];

      AST_HS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        hs_uv_i[p] |=> hs_inhibit_o[p]); // R6
    end
  endgenerate

  // Outputs start killed and inhibited until supplies are reported good
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q.kill    <= 1'b1;
      out_q.fault_n <= 1'b1;
      inh_q         <= '1;
    end else begin
      out_q <= out_d;
      inh_q <= inh_d;
    end
  end

  assign kill_o       = out_q.kill;
  assign fault_n_o    = out_q.fault_n;
  assign hs_inhibit_o = inh_q;

  AST_TRIP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    trip_qual |=> (kill_o && !fault_n_o)); // R1
  AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n_o |-> (oc_q || $past(vcc_uv_i))); // R2
  AST_VCC_UV_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_uv_i |=> (kill_o && !fault_n_o)); // R5
  AST_ENABLE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> kill_o); // R7

endmodule

// File: tb/test_drv_fault_supervisor.sv
module test_drv_fault_supervisor;

  localparam int NPH = 3;
  localparam int BLK = 4;
  localparam int CLR = 20;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           trip_i, vcc_uv_i, enable_i;
  logic [NPH-1:0] hs_uv_i;
  logic           kill_o, fault_n_o;
  logic [NPH-1:0] hs_inhibit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  drv_fault_supervisor #(.NUM_PH(NPH), .BLANK_CYC(BLK), .CLR_CYC(CLR)) i_drv_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .vcc_uv_i(vcc_uv_i),
    .hs_uv_i(hs_uv_i), .enable_i(enable_i), .kill_o(kill_o),
    .hs_inhibit_o(hs_inhibit_o), .fault_n_o(fault_n_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // {kill, fault_n, inhibit}
  function automatic logic [31:0] outs();
    return {27'd0, kill_o, fault_n_o, hs_inhibit_o};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; trip_i = 0; vcc_uv_i = 0; hs_uv_i = '0; enable_i = 1;
    step(2);
    chk("R9 reset outputs", outs(), {27'd0, 1'b1, 1'b1, 3'b111});
    rst_n = 1'b1;
    step(1);
    chk("R9 release to idle", outs(), {27'd0, 1'b0, 1'b1, 3'b000});
  endtask

  task automatic t_enable();
    enable_i = 0; step(1);
    chk("R7 enable low kills", kill_o, 1);
    chk("R7 enable leaves fault", fault_n_o, 1);
    enable_i = 1; step(1);
    chk("R7 enable not latched", kill_o, 0);
  endtask

  task automatic t_hs_uv();
    hs_uv_i = 3'b010; step(1);
    chk("R6 only phase 1 inhibited", outs(), {27'd0, 1'b0, 1'b1, 3'b010});
    hs_uv_i = 3'b101; step(1);
    chk("R6 phases 0 and 2", outs(), {27'd0, 1'b0, 1'b1, 3'b101});
    hs_uv_i = 3'b000; step(1);
    chk("R6 inhibit release", hs_inhibit_o, 0);
  endtask

  task automatic t_vcc_uv();
    vcc_uv_i = 1; step(1);
    chk("R5 vcc uv kill", kill_o, 1);
    chk("R2 vcc uv fault", fault_n_o, 0);
    step(3);
    chk("R5 vcc uv held", fault_n_o, 0);
    vcc_uv_i = 0; step(1);
    chk("R5 vcc uv not latched fault", fault_n_o, 1);
    chk("R5 vcc uv not latched kill", kill_o, 0);
  endtask

  task automatic t_glitch();
    trip_i = 1;
    for (int i = 0; i < BLK - 1; i++) begin
      step(1);
      chk("R8 glitch no kill", kill_o, 0);
    end
    trip_i = 0; step(1);
    chk("R8 glitch no fault", fault_n_o, 1);
    step(CLR + 2);
    chk("R8 glitch left nothing", outs(), {27'd0, 1'b0, 1'b1, 3'b000});
  endtask

  task automatic trip_qualify();
    trip_i = 1;
    step(BLK - 1);
    chk("R8 not yet qualified", kill_o, 0);
    step(1);
    chk("R1 trip kills", kill_o, 1);
    chk("R2 trip faults", fault_n_o, 0);
  endtask

  task automatic t_trip_clear();
    trip_qualify();
    step(5);
    trip_i = 0;
    step(CLR - 1);
    chk("R4 fault held before delay", fault_n_o, 0);
    chk("R4 kill held before delay", kill_o, 1);
    step(1);
    chk("R4 fault released", fault_n_o, 1);
    chk("R4 kill released", kill_o, 0);
  endtask

  task automatic t_restart();
    trip_qualify();
    trip_i = 0; step(10);
    trip_i = 1; step(1);
    chk("R10 single high keeps fault", fault_n_o, 0);
    trip_i = 0;
    step(CLR - 1);
    chk("R10 count restarted", fault_n_o, 0);
    step(1);
    chk("R10 release after full count", fault_n_o, 1);
  endtask

  task automatic t_set_dominant();
    trip_qualify();
    step(2 * CLR);
    chk("R3 long trip holds fault", fault_n_o, 0);
    chk("R3 long trip holds kill", kill_o, 1);
    enable_i = 0; step(1);
    chk("R7 enable no effect on fault", fault_n_o, 0);
    enable_i = 1;
    trip_i = 0; step(CLR);
    chk("R4 release after long trip", outs(), {27'd0, 1'b0, 1'b1, 3'b000});
  endtask

  initial begin
    t_reset();
    t_enable();
    t_hs_uv();
    t_vcc_uv();
    t_glitch();
    t_trip_clear();
    t_restart();
    t_set_dominant();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule